// File: doc/BRIEF.md
# NAND Flash Device Bus Front-End

This block is the device-side logic that sits behind the pins of a small parallel NAND flash memory. A single 8-bit bus carries commands, addresses and data. The block samples the asynchronous control strobes with the system clock and detects their edges. Each byte is then routed by the command-latch and address-latch levels at the end of the write strobe. Read data is driven from an internal column counter that steps on every read strobe. A timer that can be configured emulates the busy periods of read, program and erase.

The cell array is not modelled. In its place there is a behavioural page of `2^COL_W` bytes plus a staging page that is filled by data-load bytes. A program operation clears bits in the page in the way flash cells are programmed: each page byte becomes the AND of its old value and the staged byte. An erase sets every byte back to FFh. The block drives a bus output-enable (the tri-state control) and a pull-down enable for an open-drain ready/busy line.

Top module: `nand_bus_frontend`

## Requirements
- R1: After reset, rb_pull and io_oe are low and every page byte reads FFh.
- R2: A byte is taken only at a rising edge of we_n while ce_n is low. With cle high the byte is a command, even if ale is also high. With ale high and cle low it is an address byte. With both low it is a data byte.
- R3: Address bytes arrive least significant first, three per operation for the default 19-bit address. The low COL_W bits of the first address byte load the column counter. Command 00h followed by the third address byte starts a read busy period of T_READ cycles, and the page data can be read after it.
- R4: In read output, with ce_n low and re_n low, io_oe is high and io_out shows the page byte at the column counter. Each rising edge of re_n advances the column by one, and the column wraps from the last byte to byte 0.
- R5: Command 80h sets every staging byte to FFh. Each following data byte is written to the staging byte at the column, and the column then advances. Command 10h starts a program busy period of T_PROG cycles. When that period ends, each page byte becomes the AND of itself and its staging byte.
- R6: Command 60h, three address bytes and then D0h start an erase busy period of T_ERASE cycles. When it ends, every page byte is FFh.
- R7: rb_pull is high during the whole of each read, program and erase busy period, and low when no operation is running.
- R8: While busy, every byte taken at we_n other than the commands 70h and FFh has no effect.
- R9: ce_n rising during a read busy period or during read output returns the block to standby: read strobes then leave io_oe low until a new read. ce_n rising during a program or erase busy period is ignored, and the operation still completes.
- R10: If wp_n is low when 10h or D0h arrives, no busy period starts and the page is unchanged.
- R11: After command 70h, a low re_n drives the status byte onto the bus with io_oe high. The status byte has bit 7 equal to the level of wp_n, bit 6 equal to 1 when ready, and bits 5 to 0 at 0. This works during busy periods too.
- R12: Command FFh, accepted at any time, ends any running operation at once: rb_pull goes low, the block goes idle, and a pending program is not applied.
- R13: io_oe is low whenever ce_n is high or re_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command-latch level for the current byte |
| ale | input | 1 | Address-latch level for the current byte |
| we_n | input | 1 | Write strobe, active low; its rising edge takes the byte |
| re_n | input | 1 | Read strobe, active low; its rising edge advances the column |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte on the shared bus from the host |
| io_out | output | 8 | Byte driven toward the bus |
| io_oe | output | 1 | Bus driver enable; when low the pins float |
| rb_pull | output | 1 | Pull-down enable for the open-drain ready/busy line (1 = busy) |

## Verification
The routing of bytes is exercised with random columns, random lengths and random data in program-then-read rounds, with an erase now and then. A model in the bench that ANDs into the page shows whether bytes land at the right column, whether the column steps and wraps correctly, and whether the program overwrites or clears bits. Directed patterns cover the rest. A read command sent during a program busy period is checked by reading status afterwards: if the command had been accepted by mistake, page data would appear instead of the status byte. A deselect is applied in both read output and program busy, which separates standby from ignored. Sequences with write protect low and with a reset command during busy show that the page stays untouched. A byte with both latch levels high shows that the command path has priority.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ADDR,
      ST_RD_BUSY,
      ST_RD_OUT,
      ST_LOAD,
      ST_PG_BUSY,
      ST_ER_ADDR,
      ST_ER_BUSY
   } fe_state_t;

   localparam logic [7:0] OP_READ    = 8'h00;
   localparam logic [7:0] OP_LOAD    = 8'h80;
   localparam logic [7:0] OP_PROG    = 8'h10;
   localparam logic [7:0] OP_ERASE   = 8'h60;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_RESET   = 8'hFF;

endpackage

// File: rtl/nand_fe_sync.sv
module nand_fe_sync #(
   parameter int               WIDTH   = 8,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/nand_fe_timer.sv
module nand_fe_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             abort,
   output logic             busy,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (abort)      cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/nand_fe_page.sv
module nand_fe_page #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stage_clr,
   input  logic             stage_we,
   input  logic [COL_W-1:0] wcol,
   input  logic [7:0]       wdata,
   input  logic             commit,
   input  logic             erase,
   input  logic [COL_W-1:0] rcol,
   output logic [7:0]       rdata
);

   localparam int DEPTH = 1 << COL_W;

   logic [DEPTH-1:0][7:0] arr_vec;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      logic [7:0] stg_r;
      logic [7:0] arr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 stg_r <= 8'hFF;
         else if (stage_clr)                         stg_r <= 8'hFF;
         else if (stage_we && wcol == COL_W'(gi))    stg_r <= wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      arr_r <= 8'hFF;
         else if (erase)  arr_r <= 8'hFF;
         else if (commit) arr_r <= arr_r & stg_r;
      end

      assign arr_vec[gi] = arr_r;
   end

   assign rdata = arr_vec[rcol];

endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend
   import nand_fe_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int COL_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int T_READ      = 25,
   parameter int T_PROG      = 200,
   parameter int T_ERASE     = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic       re_n,
   input  logic       wp_n,
   input  logic [7:0] io_in,
   output logic [7:0] io_out,
   output logic       io_oe,
   output logic       rb_pull
);

   localparam int ADDR_CYC = (ADDR_W + 7) / 8;
   localparam int ACNT_W   = $clog2(ADDR_CYC + 1);
   localparam int T_MAX    = (T_READ > T_PROG) ? ((T_READ > T_ERASE) ? T_READ : T_ERASE)
                                               : ((T_PROG > T_ERASE) ? T_PROG : T_ERASE);
   localparam int CNT_W    = $clog2(T_MAX + 1);
   localparam int SYN_W    = 14;
   localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_CYC - 1);
   localparam logic [ACNT_W-1:0] ACNT_FULL = ACNT_W'(ADDR_CYC);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (COL_W < 1 || COL_W > 8) begin : g_bad_col
      $error("COL_W must lie in 1..8");
   end
   if (ADDR_W < COL_W || ADDR_CYC > 3) begin : g_bad_addr
      $error("ADDR_W must cover the column and fit three address bytes");
   end
   if (T_READ < 1 || T_PROG < 1 || T_ERASE < 1) begin : g_bad_time
      $error("busy durations must be at least one cycle");
   end

   // synchronised strobes and bus
   logic [SYN_W-1:0] syn_q;
   logic       ce_q, cle_q, ale_q, we_q, re_q, wp_q;
   logic [7:0] io_q;

   nand_fe_sync #(
      .WIDTH   (SYN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ce_n, cle, ale, we_n, re_n, wp_n, io_in}),
      .q     (syn_q)
   );

   assign {ce_q, cle_q, ale_q, we_q, re_q, wp_q, io_q} = syn_q;

   // edge detection
   logic ce_p, we_p, re_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_p <= 1'b1;
         we_p <= 1'b1;
         re_p <= 1'b1;
      end else begin
         ce_p <= ce_q;
         we_p <= we_q;
         re_p <= re_q;
      end
   end

   logic ce_rise, we_rise, re_rise, we_acc;
   assign ce_rise = ce_q & ~ce_p;
   assign we_rise = we_q & ~we_p;
   assign re_rise = re_q & ~re_p;
   assign we_acc  = we_rise & ~ce_q;

   logic is_cmd, is_adr, is_dat;
   assign is_cmd = we_acc & cle_q;
   assign is_adr = we_acc & ale_q & ~cle_q;
   assign is_dat = we_acc & ~ale_q & ~cle_q;

   // control state
   fe_state_t         state, st_n;
   logic [ACNT_W-1:0] acnt, acnt_n;
   logic [COL_W-1:0]  col, col_n;
   logic              stat_q, stat_n;

   logic             busy, tmr_done, tmr_load, tmr_abort;
   logic [CNT_W-1:0] tmr_val;
   logic             stage_clr, stage_we, commit, erase_go;
   logic             cmd_ok, in_addr;
   logic [7:0]       rdata;

   assign cmd_ok  = is_cmd & (~busy | io_q == OP_STATUS | io_q == OP_RESET);
   assign in_addr = (state == ST_RD_ADDR) | (state == ST_LOAD) | (state == ST_ER_ADDR);

   always_comb begin
      st_n      = state;
      acnt_n    = acnt;
      col_n     = col;
      stat_n    = stat_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      tmr_abort = 1'b0;
      stage_clr = 1'b0;
      stage_we  = 1'b0;
      commit    = 1'b0;
      erase_go  = 1'b0;

      if (tmr_done) begin
         case (state)
            ST_RD_BUSY: st_n = ST_RD_OUT;
            ST_PG_BUSY: begin commit   = 1'b1; st_n = ST_IDLE; end
            ST_ER_BUSY: begin erase_go = 1'b1; st_n = ST_IDLE; end
            default: ;
         endcase
      end

      if (ce_rise && (state == ST_RD_BUSY || state == ST_RD_OUT)) begin
         st_n      = ST_IDLE;
         stat_n    = 1'b0;
         tmr_abort = (state == ST_RD_BUSY);
      end

      if (cmd_ok) begin
         stat_n = 1'b0;
         case (io_q)
            OP_RESET:  begin st_n = ST_IDLE; tmr_abort = 1'b1; end
            OP_STATUS: stat_n = 1'b1;
            OP_READ:   begin st_n = ST_RD_ADDR; acnt_n = '0; end
            OP_LOAD:   begin st_n = ST_LOAD;    acnt_n = '0; stage_clr = 1'b1; end
            OP_ERASE:  begin st_n = ST_ER_ADDR; acnt_n = '0; end
            OP_PROG: begin
               if (state == ST_LOAD) begin
                  st_n = wp_q ? ST_PG_BUSY : ST_IDLE;
                  tmr_load = wp_q;
                  tmr_val  = CNT_W'(T_PROG);
               end
            end
            OP_CONFIRM: begin
               if (state == ST_ER_ADDR && acnt == ACNT_FULL) begin
                  st_n = wp_q ? ST_ER_BUSY : ST_IDLE;
                  tmr_load = wp_q;
                  tmr_val  = CNT_W'(T_ERASE);
               end
            end
            default: ;
         endcase
      end

      if (is_adr && !busy && in_addr && acnt < ACNT_FULL) begin
         acnt_n = acnt + 1'b1;
         if (acnt == '0 && state != ST_ER_ADDR) col_n = io_q[COL_W-1:0];
         if (state == ST_RD_ADDR && acnt == ACNT_LAST) begin
            st_n     = ST_RD_BUSY;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_READ);
         end
      end

      if (is_dat && !busy && state == ST_LOAD) begin
         stage_we = 1'b1;
         col_n    = col + 1'b1;
      end

      if (re_rise && !ce_q && state == ST_RD_OUT && !stat_q) col_n = col + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         acnt   <= '0;
         col    <= '0;
         stat_q <= 1'b0;
      end else begin
         state  <= st_n;
         acnt   <= acnt_n;
         col    <= col_n;
         stat_q <= stat_n;
      end
   end

   nand_fe_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .abort    (tmr_abort),
      .busy     (busy),
      .done     (tmr_done)
   );

   nand_fe_page #(.COL_W(COL_W)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .stage_clr (stage_clr),
      .stage_we  (stage_we),
      .wcol      (col),
      .wdata     (io_q),
      .commit    (commit),
      .erase     (erase_go),
      .rcol      (col),
      .rdata     (rdata)
   );

   assign io_out  = stat_q ? {wp_q, ~busy, 6'b0} : rdata;
   assign io_oe   = ~ce_q & ~re_q & (stat_q | (state == ST_RD_OUT));
   assign rb_pull = busy;

endmodule

// File: rtl/nand_fe_checker.sv
module nand_fe_checker
   import nand_fe_pkg::*;
#(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_q,
   input logic             re_q,
   input logic             wp_q,
   input logic             we_acc,
   input logic             ce_rise,
   input logic [7:0]       io_q,
   input logic             io_oe,
   input logic             rb_pull,
   input logic             tmr_done,
   input fe_state_t        state,
   input logic [COL_W-1:0] col
);

   AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe |-> (!ce_q && !re_q)); // R13

   AST_PROG_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PG_BUSY || state == ST_ER_BUSY || state == ST_RD_BUSY) |-> rb_pull); // R7

   AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && !wp_q && !rb_pull) |=> !rb_pull); // R10

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_pull && !tmr_done && we_acc && io_q != OP_STATUS && io_q != OP_RESET)
      |=> ($stable(state) && $stable(col))); // R8

   AST_DESELECT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_rise && !tmr_done && (state == ST_PG_BUSY || state == ST_ER_BUSY)) |=> rb_pull); // R9

   AST_DESELECT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_rise && state == ST_RD_OUT) |=> (state == ST_IDLE)); // R9

endmodule

bind nand_bus_frontend nand_fe_checker #(.COL_W(COL_W)) u_fe_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_q     (ce_q),
   .re_q     (re_q),
   .wp_q     (wp_q),
   .we_acc   (we_acc),
   .ce_rise  (ce_rise),
   .io_q     (io_q),
   .io_oe    (io_oe),
   .rb_pull  (rb_pull),
   .tmr_done (tmr_done),
   .state    (state),
   .col      (col)
);

// File: tb/nand_bus_frontend_bench.sv
module nand_bus_frontend_bench;

   localparam int COLW = 4;
   localparam int DEP  = 1 << COLW;
   localparam int TRD  = 12;
   localparam int TPG  = 60;
   localparam int TER  = 80;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
   logic [7:0] io_in = 8'h00;
   logic [7:0] io_out;
   logic       io_oe;
   logic       rb_pull;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   fin = 1'b0;
   logic [7:0] mdl [DEP];

   always #2 clk = ~clk;

   nand_bus_frontend #(
      .ADDR_W(19), .COL_W(COLW), .SYNC_STAGES(2),
      .T_READ(TRD), .T_PROG(TPG), .T_ERASE(TER)
   ) u_nand_bus_frontend (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
      .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .rb_pull(rb_pull)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic put(input logic c, input logic a, input logic [7:0] d);
      cle = c; ale = a; io_in = d;
      tick(2);
      we_n = 1'b0;
      tick(3);
      we_n = 1'b1;
      tick(3);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] d); put(1'b1, 1'b0, d); endtask
   task automatic adr(input logic [7:0] d); put(1'b0, 1'b1, d); endtask
   task automatic dat(input logic [7:0] d); put(1'b0, 1'b0, d); endtask

   task automatic rd(output logic [7:0] v, output logic oe);
      re_n = 1'b0;
      tick(4);
      v = io_out; oe = io_oe;
      re_n = 1'b1;
      tick(4);
   endtask

   task automatic read_from(input int c);
      cmd(8'h00); adr(8'(c)); adr(8'h00); adr(8'h00);
      tick(TRD + 6);
   endtask

   task automatic load_start(input int c);
      cmd(8'h80); adr(8'(c)); adr(8'h00); adr(8'h00);
   endtask

   function automatic logic [7:0] exp_at(input int c);
      return mdl[c % DEP];
   endfunction

   initial begin : main
      logic [7:0] v;
      logic       oe;
      int         c, len;
      logic [7:0] bytes [4];
      void'($urandom(32'd4711));
      for (int i = 0; i < DEP; i++) mdl[i] = 8'hFF;

      tick(3); rst_n = 1'b1; tick(3);
      check("R1 rb_pull after reset", rb_pull, 1'b0);
      check("R1 io_oe after reset", io_oe, 1'b0);
      ce_n = 1'b0; tick(4);

      // R3 read of erased page, R13 oe low while re_n high
      read_from(0);
      check("R13 io_oe with re_n high", io_oe, 1'b0);
      rd(v, oe);
      check("R1 erased byte", v, 8'hFF);
      check("R4 io_oe in read", oe, 1'b1);

      // R5 program two bytes, R7 busy
      load_start(3); dat(8'hA5); dat(8'h3C); cmd(8'h10);
      tick(1);
      check("R7 busy during program", rb_pull, 1'b1);
      tick(TPG + 2);
      check("R7 ready after program", rb_pull, 1'b0);
      mdl[3] &= 8'hA5; mdl[4] &= 8'h3C;
      read_from(3);
      rd(v, oe); check("R5 byte 3", v, exp_at(3));
      rd(v, oe); check("R4 column advance", v, exp_at(4));

      // R4 wrap of the column
      read_from(DEP - 1);
      rd(v, oe); check("R4 last byte", v, exp_at(DEP - 1));
      rd(v, oe); check("R4 wrap to byte 0", v, exp_at(0));

      // R5 AND semantics: program byte 3 again
      load_start(3); dat(8'h0F); cmd(8'h10); tick(TPG + 3);
      mdl[3] &= 8'h0F;
      read_from(3); rd(v, oe); check("R5 second program clears bits", v, exp_at(3));

      // R11 status during busy, R8 read command ignored while busy
      load_start(5); dat(8'h0F); cmd(8'h10);
      mdl[5] &= 8'h0F;
      cmd(8'h70);
      rd(v, oe);
      check("R11 status busy", v, 8'h80);
      check("R11 status oe", oe, 1'b1);
      cmd(8'h00); adr(8'h06);
      tick(TPG);
      rd(v, oe);
      check("R8 ignored read keeps status view", v, 8'hC0);
      read_from(5); rd(v, oe); check("R5 program byte 5", v, exp_at(5));

      // R9 deselect during program busy is ignored
      load_start(8); dat(8'h55); cmd(8'h10);
      tick(2); ce_n = 1'b1; tick(6);
      check("R9 busy kept on deselect", rb_pull, 1'b1);
      ce_n = 1'b0; tick(TPG);
      check("R9 program completes", rb_pull, 1'b0);
      mdl[8] &= 8'h55;
      read_from(8); rd(v, oe); check("R9 programmed after deselect", v, exp_at(8));

      // R9 deselect during read output -> standby, R13
      read_from(3); rd(v, oe);
      ce_n = 1'b1; tick(5);
      re_n = 1'b0; tick(4);
      check("R13 io_oe with ce_n high", io_oe, 1'b0);
      re_n = 1'b1; tick(2);
      ce_n = 1'b0; tick(5);
      rd(v, oe);
      check("R9 standby keeps io_oe low", oe, 1'b0);

      // R10 write protect
      wp_n = 1'b0; tick(4);
      load_start(2); dat(8'h00); cmd(8'h10);
      tick(1);
      check("R10 no busy while protected", rb_pull, 1'b0);
      cmd(8'h70); rd(v, oe);
      check("R11 status with wp low", v, 8'h40);
      wp_n = 1'b1; tick(4);
      read_from(2); rd(v, oe); check("R10 page unchanged", v, exp_at(2));

      // R2 cle and ale both high -> command
      put(1'b1, 1'b1, 8'h70);
      rd(v, oe);
      check("R2 cle priority over ale", v, 8'hC0);

      // R12 reset command aborts program
      load_start(1); dat(8'h00); cmd(8'h10);
      tick(1);
      check("R12 busy before reset", rb_pull, 1'b1);
      cmd(8'hFF);
      check("R12 ready after reset", rb_pull, 1'b0);
      read_from(1); rd(v, oe); check("R12 program not applied", v, exp_at(1));

      // R6 erase
      cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
      tick(1);
      check("R6 busy during erase", rb_pull, 1'b1);
      tick(TER + 3);
      check("R6 ready after erase", rb_pull, 1'b0);
      for (int i = 0; i < DEP; i++) mdl[i] = 8'hFF;
      read_from(3); rd(v, oe); check("R6 erased byte 3", v, 8'hFF);
      rd(v, oe); check("R6 erased byte 4", v, 8'hFF);

      // random program / read rounds (R2, R3, R4, R5, R6)
      for (int it = 0; it < 10; it++) begin
         c   = int'($urandom % DEP);
         len = 1 + int'($urandom % 4);
         if ($urandom % 5 == 0) begin
            cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
            tick(TER + 3);
            for (int i = 0; i < DEP; i++) mdl[i] = 8'hFF;
         end
         load_start(c);
         for (int k = 0; k < len; k++) begin
            bytes[k] = 8'($urandom);
            dat(bytes[k]);
            mdl[(c + k) % DEP] &= bytes[k];
         end
         cmd(8'h10); tick(TPG + 3);
         read_from(c);
         for (int k = 0; k < len; k++) begin
            rd(v, oe);
            check("R5 random readback", v, exp_at(c + k));
         end
      end

      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule